// File: doc/BRIEF.md
# Host Transmit Ethernet Framer

This block sits between the host-side transmit path and the network transmit path. Frames from the host arrive as two separate streams. A metadata stream carries one item per frame: the byte count, a user header descriptor and a channel number. A data stream carries the frame bytes as words, marked with start-of-frame, end-of-frame and the last valid byte position. The block merges the two into a single Ethernet transmit data stream. Each frame's transmit header appears on a sideband bus, and that bus is meaningful only in the word that starts the frame.

The block pairs each metadata item with the start word of one data frame. Whichever input arrives first waits for the other. Frames shorter than the 60-byte minimum are extended with zero bytes, and the header length field reports the extended size. While padding-only words are being produced, the data input is held not-ready. No checksum is appended; that happens further along the transmit path.

Top module: `host_eth_txfr`

## Requirements
- R1: While reset is held, and afterwards with idle inputs, `tx_valid`, `hm_ready` and `hd_ready` are all 0.
- R2: A metadata item is accepted only in the same cycle as a start-of-frame data word. A start-of-frame data word is never accepted while no metadata item is offered. Each output frame start corresponds to exactly one accepted metadata item.
- R3: On the start-of-frame output word, `tx_hdr[15:0]` equals max(metadata length, 60). `tx_hdr[23:16]` equals the metadata channel, zero-extended. `tx_hdr[24]` (drop request) is 0. On every other output word, `tx_hdr` is all zeros.
- R4: The bytes of a frame leave in their original order and word positions, with byte i of the frame in word i/8 at byte lane i%8 (lane 0 at bits 7:0). A frame of 60 bytes or more ends on the same word and at the same end position (`tx_eof_pos` = index of the last valid lane) as its input.
- R5: A frame shorter than 60 bytes is emitted as exactly 8 words, with `tx_eof_pos` = 3 on the last word. Every byte beyond the frame's own data is zero, including bytes that were beyond the input end position of its last input word.
- R6: The data input is never accepted while padding-only words of the previous frame are still to be produced. Every accepted data word enters the output in sequence, directly behind the output words already produced.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, the output word and all its sideband fields stay unchanged.
- R8: The user header descriptor `hm_desc` (header length in bits 7:0, type in bits 11:8) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hm_valid | input | 1 | Metadata item offered |
| hm_ready | output | 1 | Metadata item accepted |
| hm_len | input | LEN_W | Frame length in bytes |
| hm_desc | input | DESC_W | User header descriptor (length 7:0, type 11:8) |
| hm_chan | input | CH_W | Destination channel |
| hd_valid | input | 1 | Data word offered |
| hd_ready | output | 1 | Data word accepted |
| hd_data | input | BPW*8 | Data word, lane 0 in the low byte |
| hd_sof | input | 1 | Word starts a frame |
| hd_eof | input | 1 | Word ends a frame |
| hd_eof_pos | input | log2(BPW) | Index of last valid lane when `hd_eof` is 1 |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Output word accepted |
| tx_data | output | BPW*8 | Output word |
| tx_sof | output | 1 | Output word starts a frame |
| tx_eof | output | 1 | Output word ends a frame |
| tx_eof_pos | output | log2(BPW) | Index of last valid lane on an end word |
| tx_hdr | output | LEN_W+PORT_W+1 | Transmit header, meaningful on start words |

## Verification
The assertions assume well-formed input framing. Data frames arrive as a start word, then body words, then exactly one end word, with no data word offered outside a frame. The descriptor must carry known values whenever metadata is offered. The stimulus keeps to these rules by building each frame from its length alone, with one metadata item per frame. The valid gaps and the output ready pattern are drawn at random, and the metadata for the first frame is held back so that the data side has to wait.

// File: rtl/tx_fr_pkg.sv
package tx_fr_pkg;

  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,
    ST_BODY = 2'd1,
    ST_PAD  = 2'd2
  } st_e;

  // length advertised in the transmit header: never below the minimum
  function automatic int fill_len(input int len, input int min_len);
    return (len < min_len) ? min_len : len;
  endfunction

  // true when a frame ending at word idx, lane pos is under the minimum
  function automatic bit frame_short(input int idx, input int pos,
                                     input int bpw, input int min_len);
    return (idx * bpw + pos + 1) < min_len;
  endfunction

endpackage

// File: rtl/tx_fr_ctrl.sv
module tx_fr_ctrl
  import tx_fr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic m_valid,
  input  logic d_valid,
  input  logic d_sof,
  input  logic d_eof,
  input  logic load_en,
  input  logic go_pad,
  input  logic pad_last,
  output logic m_ready,
  output logic d_ready,
  output logic ld_head,
  output logic ld_body,
  output logic ld_pad,
  output logic in_head
);

  st_e st, st_nx;

  always_comb begin
    ld_head = (st == ST_HEAD) && m_valid && d_valid && d_sof && load_en;
    ld_body = (st == ST_BODY) && d_valid && load_en;
    ld_pad  = (st == ST_PAD) && load_en;
    m_ready = ld_head;
    d_ready = ld_head | ld_body;
    in_head = (st == ST_HEAD);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_HEAD: if (ld_head) st_nx = !d_eof ? ST_BODY : (go_pad ? ST_PAD : ST_HEAD);
      ST_BODY: if (ld_body && d_eof) st_nx = go_pad ? ST_PAD : ST_HEAD;
      ST_PAD:  if (ld_pad && pad_last) st_nx = ST_HEAD;
      default: st_nx = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_HEAD;
    else        st <= st_nx;
  end

endmodule

// File: rtl/tx_fr_wcnt.sv
module tx_fr_wcnt #(
  parameter int LIMIT = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_head,
  input  logic          step,
  output logic [CW-1:0] widx
);

  logic [CW-1:0] cnt;

  // index of the word being produced now; a frame start is always word 0
  assign widx = in_head ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= (int'(widx) >= LIMIT) ? CW'(LIMIT) : widx + 1'b1;
  end

endmodule

// File: rtl/tx_fr_oreg.sv
module tx_fr_oreg #(
  parameter int DW    = 64,
  parameter int POS_W = 3,
  parameter int HDR_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [POS_W-1:0] in_pos,
  input  logic [HDR_W-1:0] in_hdr,
  output logic             load_en,
  output logic             valid,
  input  logic             ready,
  output logic [DW-1:0]    data,
  output logic             sof,
  output logic             eof,
  output logic [POS_W-1:0] pos,
  output logic [HDR_W-1:0] hdr
);

  assign load_en = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      sof   <= 1'b0;
      eof   <= 1'b0;
      pos   <= '0;
      hdr   <= '0;
    end else if (load_en) begin
      valid <= load;
      if (load) begin
        data <= in_data;
        sof  <= in_sof;
        eof  <= in_eof;
        pos  <= in_pos;
        hdr  <= in_hdr;
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data) && $stable(sof) &&
                           $stable(eof) && $stable(pos) && $stable(hdr)));

endmodule

// File: rtl/host_eth_txfr.sv
module host_eth_txfr
  import tx_fr_pkg::*;
#(
  parameter int BPW     = 8,
  parameter int MIN_LEN = 60,
  parameter int LEN_W   = 16,
  parameter int CH_W    = 4,
  parameter int PORT_W  = 8,
  parameter int DESC_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hm_valid,
  output logic                      hm_ready,
  input  logic [LEN_W-1:0]          hm_len,
  input  logic [DESC_W-1:0]         hm_desc,
  input  logic [CH_W-1:0]           hm_chan,
  input  logic                      hd_valid,
  output logic                      hd_ready,
  input  logic [BPW*8-1:0]          hd_data,
  input  logic                      hd_sof,
  input  logic                      hd_eof,
  input  logic [$clog2(BPW)-1:0]    hd_eof_pos,
  output logic                      tx_valid,
  input  logic                      tx_ready,
  output logic [BPW*8-1:0]          tx_data,
  output logic                      tx_sof,
  output logic                      tx_eof,
  output logic [$clog2(BPW)-1:0]    tx_eof_pos,
  output logic [LEN_W+PORT_W:0]     tx_hdr
);

  localparam int DW        = BPW * 8;
  localparam int POS_W     = $clog2(BPW);
  localparam int HDR_W     = LEN_W + PORT_W + 1;
  localparam int MIN_WORDS = (MIN_LEN + BPW - 1) / BPW;
  localparam int MIN_LAST  = (MIN_LEN - 1) % BPW;
  localparam int CNT_W     = $clog2(MIN_WORDS + 1);

  // zero every lane above 'last'
  function automatic logic [DW-1:0] keep_upto(input logic [DW-1:0] d,
                                               input logic [POS_W-1:0] last);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < BPW; i++)
      if (i <= int'(last)) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  // named internal events
  logic             ld_head, ld_body, ld_pad, load, load_en, in_head;
  logic             short_eof, go_pad, pad_last;
  logic [CNT_W-1:0] widx;

  logic [DW-1:0]    nx_data;
  logic             nx_sof, nx_eof;
  logic [POS_W-1:0] nx_pos;
  logic [HDR_W-1:0] nx_hdr;

  assign short_eof = hd_eof && frame_short(int'(widx), int'(hd_eof_pos), BPW, MIN_LEN);
  assign go_pad    = short_eof && (int'(widx) < MIN_WORDS - 1);
  assign pad_last  = (int'(widx) == MIN_WORDS - 1);
  assign load      = ld_head | ld_body | ld_pad;

  tx_fr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_valid  (hm_valid),
    .d_valid  (hd_valid),
    .d_sof    (hd_sof),
    .d_eof    (hd_eof),
    .load_en  (load_en),
    .go_pad   (go_pad),
    .pad_last (pad_last),
    .m_ready  (hm_ready),
    .d_ready  (hd_ready),
    .ld_head  (ld_head),
    .ld_body  (ld_body),
    .ld_pad   (ld_pad),
    .in_head  (in_head)
  );

  tx_fr_wcnt #(.LIMIT(MIN_WORDS), .CW(CNT_W)) u_wcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_head (in_head),
    .step    (load),
    .widx    (widx)
  );

  always_comb begin
    nx_data = '0;
    nx_sof  = 1'b0;
    nx_eof  = 1'b0;
    nx_pos  = '0;
    nx_hdr  = '0;
    if (ld_pad) begin
      nx_eof = pad_last;
      if (pad_last) nx_pos = POS_W'(MIN_LAST);
    end else begin
      nx_data = keep_upto(hd_data, hd_eof ? hd_eof_pos : POS_W'(BPW - 1));
      nx_sof  = ld_head;
      nx_eof  = hd_eof && !go_pad;
      if (nx_eof) nx_pos = short_eof ? POS_W'(MIN_LAST) : hd_eof_pos;
      if (ld_head)
        nx_hdr = {1'b0, PORT_W'(hm_chan), LEN_W'(fill_len(int'(hm_len), MIN_LEN))};
    end
  end

  tx_fr_oreg #(.DW(DW), .POS_W(POS_W), .HDR_W(HDR_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .in_data (nx_data),
    .in_sof  (nx_sof),
    .in_eof  (nx_eof),
    .in_pos  (nx_pos),
    .in_hdr  (nx_hdr),
    .load_en (load_en),
    .valid   (tx_valid),
    .ready   (tx_ready),
    .data    (tx_data),
    .sof     (tx_sof),
    .eof     (tx_eof),
    .pos     (tx_eof_pos),
    .hdr     (tx_hdr)
  );

  // ---------------- port-level trackers for the assertions ----------------
  logic [1:0]       pend;      // metadata accepted but its start word not yet out
  logic             src_done;  // input end word taken, output end word not yet out
  logic [CNT_W-1:0] oidx;      // index of the word now on tx_data
  logic             m_hs, sof_hs, eof_hs, d_end_hs;

  assign m_hs     = hm_valid && hm_ready;
  assign sof_hs   = tx_valid && tx_ready && tx_sof;
  assign eof_hs   = tx_valid && tx_ready && tx_eof;
  assign d_end_hs = hd_valid && hd_ready && hd_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      src_done <= 1'b0;
      oidx     <= '0;
    end else begin
      pend <= pend + {1'b0, m_hs} - {1'b0, sof_hs};
      if (d_end_hs)    src_done <= 1'b1;
      else if (eof_hs) src_done <= 1'b0;
      if (tx_valid && tx_ready)
        oidx <= tx_eof ? '0 : ((int'(oidx) >= MIN_WORDS) ? CNT_W'(MIN_WORDS) : oidx + 1'b1);
    end
  end

  // R2
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= 2'd1) && ((tx_valid && tx_sof) -> (pend == 2'd1)));

  // R3
  hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sof) |-> ((tx_hdr[LEN_W-1:0] >= LEN_W'(MIN_LEN)) && !tx_hdr[HDR_W-1]));

  // R5
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_eof) |-> ((int'(oidx) * BPW + int'(tx_eof_pos) + 1) >= MIN_LEN));

  // R6
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_done && !eof_hs) |-> !hd_ready);

  // R8 (descriptor is carried in but never steers the output; it must be known)
  desc_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hm_valid |-> !$isunknown(hm_desc));

endmodule

// File: tb/host_eth_txfr_tb.sv
module host_eth_txfr_tb;

  localparam int BPW = 8, DW = 64, POS_W = 3, LEN_W = 16, CH_W = 4, DESC_W = 12;
  localparam int HDR_W = 25, MIN_LEN = 60, NF = 34, MAXL = 1514;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              hm_valid, hm_ready;
  logic [LEN_W-1:0]  hm_len;
  logic [DESC_W-1:0] hm_desc;
  logic [CH_W-1:0]   hm_chan;
  logic              hd_valid, hd_ready, hd_sof, hd_eof;
  logic [DW-1:0]     hd_data;
  logic [POS_W-1:0]  hd_eof_pos;
  logic              tx_valid, tx_ready, tx_sof, tx_eof;
  logic [DW-1:0]     tx_data;
  logic [POS_W-1:0]  tx_eof_pos;
  logic [HDR_W-1:0]  tx_hdr;

  host_eth_txfr u_dut (
    .clk(clk), .rst_n(rst_n),
    .hm_valid(hm_valid), .hm_ready(hm_ready), .hm_len(hm_len), .hm_desc(hm_desc), .hm_chan(hm_chan),
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data), .hd_sof(hd_sof),
    .hd_eof(hd_eof), .hd_eof_pos(hd_eof_pos),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_eof_pos(tx_eof_pos), .tx_hdr(tx_hdr)
  );

  int lens [NF];
  int chans[NF];
  int base [NF];
  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  int d_gidx = 0;

  function automatic logic [7:0] fbyte(input int k, input int b);
    return 8'((k * 37 + b * 13 + 5) & 255);
  endfunction
  function automatic int tot_len(input int l);
    return (l < MIN_LEN) ? MIN_LEN : l;
  endfunction
  function automatic int out_words(input int l);
    return (tot_len(l) + BPW - 1) / BPW;
  endfunction
  function automatic logic [DW-1:0] exp_word(input int k, input int w);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < BPW; i++)
      if (w * BPW + i < lens[k]) r[i*8 +: 8] = fbyte(k, w * BPW + i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- metadata driver ----------------
  initial begin
    hm_valid = 0; hm_len = '0; hm_desc = '0; hm_chan = '0;
    wait (started);
    for (int k = 0; k < NF; k++) begin
      int gap;
      gap = (k == 0) ? 12 : int'($urandom_range(0, 3));
      repeat (gap) begin @(posedge clk); #1; end
      hm_valid = 1;
      hm_len   = LEN_W'(lens[k]);
      hm_chan  = CH_W'(chans[k]);
      hm_desc  = DESC_W'($urandom);   // R8: random descriptor, outputs must not depend on it
      @(negedge clk);
      while (!hm_ready) @(negedge clk);
      @(posedge clk); #1;
      hm_valid = 0;
    end
  end

  // ---------------- data driver ----------------
  initial begin
    hd_valid = 0; hd_data = '0; hd_sof = 0; hd_eof = 0; hd_eof_pos = '0;
    wait (started);
    for (int k = 0; k < NF; k++) begin
      int nw;
      nw = (lens[k] + BPW - 1) / BPW;
      for (int j = 0; j < nw; j++) begin
        if ($urandom_range(0, 3) == 0) begin @(posedge clk); #1; end
        for (int i = 0; i < BPW; i++)
          hd_data[i*8 +: 8] = (j * BPW + i < lens[k]) ? fbyte(k, j * BPW + i) : 8'($urandom);
        hd_sof     = (j == 0);
        hd_eof     = (j == nw - 1);
        hd_eof_pos = POS_W'((lens[k] - 1) % BPW);
        d_gidx     = base[k] + j;
        hd_valid   = 1;
        @(negedge clk);
        while (!hd_ready) @(negedge clk);
        @(posedge clk); #1;
        hd_valid = 0;
      end
    end
  end

  // ---------------- output sink ----------------
  initial begin
    tx_ready = 0;
    wait (started);
    forever begin
      @(posedge clk); #1;
      tx_ready = ($urandom_range(0, 99) < 65);
    end
  end

  // ---------------- checker ----------------
  int of_k = 0, of_w = 0, handed = 0;
  bit prev_stall = 0;
  logic [DW-1:0] p_data; logic p_sof, p_eof; logic [POS_W-1:0] p_pos; logic [HDR_W-1:0] p_hdr;

  always @(negedge clk) begin
    if (started && !done) begin
      // R2: start word never taken without metadata; metadata only with a start word
      if (hd_valid && hd_sof && !hm_valid)
        chk(!hd_ready, "R2", "sof accepted without metadata", 64'(hd_ready), 64'd0);
      if (hm_valid && hm_ready)
        chk(hd_valid && hd_ready && hd_sof, "R2", "metadata taken without sof word",
            64'(hd_valid && hd_ready && hd_sof), 64'd1);
      // R6: accepted word lands directly behind the words already produced
      if (hd_valid && hd_ready)
        chk(d_gidx == handed + (tx_valid ? 1 : 0), "R6", "data accepted out of sequence",
            64'(d_gidx), 64'(handed + (tx_valid ? 1 : 0)));
      // R7
      if (prev_stall)
        chk(tx_valid && tx_data == p_data && tx_sof == p_sof && tx_eof == p_eof &&
            tx_eof_pos == p_pos && tx_hdr == p_hdr, "R7", "output changed under stall",
            tx_data, p_data);
      prev_stall = tx_valid && !tx_ready;
      p_data = tx_data; p_sof = tx_sof; p_eof = tx_eof; p_pos = tx_eof_pos; p_hdr = tx_hdr;

      if (tx_valid && tx_ready) begin
        int nw;
        bit last;
        string rq;
        logic [HDR_W-1:0] eh;
        nw   = out_words(lens[of_k]);
        last = (of_w == nw - 1);
        rq   = (lens[of_k] < MIN_LEN) ? "R5" : "R4";
        chk(tx_data == exp_word(of_k, of_w), rq, "data word", tx_data, exp_word(of_k, of_w));
        chk(tx_eof == last, rq, "end flag", 64'(tx_eof), 64'(last));
        if (last)
          chk(int'(tx_eof_pos) == (tot_len(lens[of_k]) - 1) % BPW, rq, "end position",
              64'(tx_eof_pos), 64'((tot_len(lens[of_k]) - 1) % BPW));
        chk(tx_sof == (of_w == 0), "R4", "start flag", 64'(tx_sof), 64'(of_w == 0));
        // R3 header: {drop=0, port=channel, length=max(len,60)} on start word, else zero
        eh = (of_w == 0) ? {1'b0, 8'(chans[of_k]), 16'(tot_len(lens[of_k]))} : '0;
        chk(tx_hdr == eh, "R3", "transmit header", 64'(tx_hdr), 64'(eh));
        handed++;
        if (last) begin
          of_k++; of_w = 0;
          if (of_k == NF) done = 1;
        end else of_w++;
      end
    end
  end

  // ---------------- main ----------------
  initial begin
    int acc;
    void'($urandom(32'd20250611));
    lens[0] = 1;  lens[1] = 59; lens[2] = 60; lens[3] = 61; lens[4] = MAXL;
    lens[5] = 8;  lens[6] = 56; lens[7] = 57; lens[8] = 64; lens[9] = 52;
    for (int k = 10; k < NF; k++) lens[k] = int'($urandom_range(1, 200));
    acc = 0;
    for (int k = 0; k < NF; k++) begin
      chans[k] = int'($urandom_range(0, 15));
      base[k]  = acc;
      acc += out_words(lens[k]);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!tx_valid, "R1", "tx_valid in reset", 64'(tx_valid), 64'd0);
    chk(!hm_ready, "R1", "hm_ready in reset", 64'(hm_ready), 64'd0);
    chk(!hd_ready, "R1", "hd_ready in reset", 64'(hd_ready), 64'd0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !hm_ready && !hd_ready, "R1", "idle after reset",
        64'({tx_valid, hm_ready, hd_ready}), 64'd0);
    @(posedge clk); #1;
    started = 1;

    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, frames seen %0d expected %0d", of_k, NF);
      end
    join_any
    disable fork;
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule